// File: doc/BRIEF.md
# Opcode Register with Interrupt Injection

This block holds the instruction opcode of a microcoded 8-bit processor. The control unit pulses a load strobe when it wants the next opcode taken from the data bus. The block also keeps an interrupt-enable flag, which microcode sets and clears with two separate strobes.

When a load is requested while the flag is set and an interrupt request is pending, the register is zeroed on that clock edge instead of taking the bus byte. The decoder then sees opcode 0, which is reserved for the interrupt entry instruction. No multiplexer is needed on the data path. The interrupt entry microcode clears the flag, and the return-from-interrupt microcode sets it again. The interrupt request is a level: it stays pending until the source is acknowledged.

Top module: `op_irq_reg`

## Requirements
- R1: While reset is active and on the first cycle after it, the opcode output is 0x00 and the interrupt-enable output is 0.
- R2: With the enable flag at 0, a load strobe puts the bus byte into the opcode register on the next clock edge, whatever the interrupt request input is.
- R3: With the enable flag at 1 and no interrupt request, a load strobe puts the bus byte into the opcode register on the next clock edge.
- R4: A load strobe with the enable flag at 1 and the interrupt request at 1 makes the opcode 0x00 on the next clock edge. The opcode does not change before that edge. The flag value used is the one held before the edge, even if a clear strobe arrives in the same cycle.
- R5: When no load strobe is given, the opcode holds its value, whatever the interrupt request, the bus and the enable flag do.
- R6: A set strobe alone makes the enable output 1 after the next clock edge.
- R7: A clear strobe makes the enable output 0 after the next clock edge. When set and clear strobes come in the same cycle, clear wins.
- R8: The interrupt request is sampled as a level, each time a load occurs. The injection itself leaves the enable flag unchanged, so a request that is still held injects again at the next enabled load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_din | input | 8 | Byte from the data bus, candidate opcode |
| op_load | input | 1 | Load-opcode strobe from the control unit |
| irq_req | input | 1 | Interrupt request level |
| ien_set | input | 1 | Microcode strobe that sets the enable flag |
| ien_clr | input | 1 | Microcode strobe that clears the enable flag |
| opcode | output | 8 | Current opcode |
| ien | output | 1 | Current interrupt-enable flag |

## Verification
The load path is driven with each combination of enable flag and request level. Bus bytes are nonzero, so a real load of the byte can be told apart from an injected zero. The request is toggled on cycles without a load to show that it does nothing unless a load is present. Loads are repeated while the request stays high, to show that injection is level-based and does not clear the flag by itself. A clear strobe in the same cycle as an injecting load shows that the decision uses the flag value held before the edge. A mid-run reset shows that both state elements return to zero.

// File: rtl/opr_pkg.sv
package opr_pkg;
    localparam int OP_W = 8;
    localparam logic [OP_W-1:0] IRQ_OPCODE = '0;

    typedef struct packed {
        logic [OP_W-1:0] opcode;
    } op_state_t;

    typedef struct packed {
        logic en;
    } ien_state_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_INJECT = 2'd2
    } op_action_e;
endpackage

// File: rtl/opr_ien_ff.sv
module opr_ien_ff
    import opr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic en_o
);
    ien_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.en = 1'b0;
        else if (set_i)
            st_d.en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/opr_inject.sv
module opr_inject
    import opr_pkg::*;
(
    input  logic       load_i,
    input  logic       en_i,
    input  logic       irq_i,
    output op_action_e act_o
);
    always_comb begin
        if (!load_i)
            act_o = OP_HOLD;
        else if (en_i && irq_i)
            act_o = OP_INJECT;
        else
            act_o = OP_LOAD;
    end
endmodule

// File: rtl/opr_op_reg.sv
module opr_op_reg
    import opr_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  op_action_e   act_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] value;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (act_i)
            OP_LOAD:   st_d.value = din_i;
            OP_INJECT: st_d.value = W'(IRQ_OPCODE);
            default:   st_d.value = st_q.value;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign q_o = st_q.value;
endmodule

// File: rtl/op_irq_reg.sv
module op_irq_reg
    import opr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] bus_din,
    input  logic            op_load,
    input  logic            irq_req,
    input  logic            ien_set,
    input  logic            ien_clr,
    output logic [OP_W-1:0] opcode,
    output logic            ien
);
    op_action_e act;
    logic       en_q;

    opr_ien_ff u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ien_set),
        .clr_i (ien_clr),
        .en_o  (en_q)
    );

    opr_inject u_inj (
        .load_i (op_load),
        .en_i   (en_q),
        .irq_i  (irq_req),
        .act_o  (act)
    );

    opr_op_reg #(.W(OP_W)) u_op (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .din_i (bus_din),
        .q_o   (opcode)
    );

    assign ien = en_q;
endmodule

// File: rtl/op_irq_reg_chk.sv
module op_irq_reg_chk
    import opr_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] bus_din,
    input logic            op_load,
    input logic            irq_req,
    input logic            ien_set,
    input logic            ien_clr,
    input logic [OP_W-1:0] opcode,
    input logic            ien
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (opcode == '0 && !ien)); // R1
    AST_LOAD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_load && !ien) |=> opcode == $past(bus_din)); // R2
    AST_LOAD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_load && ien && !irq_req) |=> opcode == $past(bus_din)); // R3
    AST_INJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_load && ien && irq_req) |=> opcode == '0); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_load |=> $stable(opcode)); // R5
    AST_IEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_set && !ien_clr) |=> ien); // R6
    AST_IEN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ien_clr |=> !ien); // R7
    AST_INJECT_KEEPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_load && ien && irq_req && !ien_set && !ien_clr) |=> ien); // R8
endmodule

bind op_irq_reg op_irq_reg_chk u_chk (.*);

// File: tb/op_irq_reg_tb.sv
`timescale 1ns/100ps
module op_irq_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_din = '0;
    logic       op_load = 1'b0;
    logic       irq_req = 1'b0;
    logic       ien_set = 1'b0;
    logic       ien_clr = 1'b0;
    logic [7:0] opcode;
    logic       ien;
    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    op_irq_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_din(bus_din), .op_load(op_load),
        .irq_req(irq_req), .ien_set(ien_set), .ien_clr(ien_clr),
        .opcode(opcode), .ien(ien)
    );

    // {set, clr, load, irq, din[7:0], exp_opcode[7:0], exp_ien}
    localparam int NV = 14;
    localparam logic [20:0] TBL [NV] = '{
        {4'b0011, 8'hA5, 8'hA5, 1'b0},  // R2 load while disabled, irq high
        {4'b0001, 8'h11, 8'hA5, 1'b0},  // R5 no load, irq high
        {4'b1000, 8'h22, 8'hA5, 1'b1},  // R6 set
        {4'b0010, 8'h3C, 8'h3C, 1'b1},  // R3 load enabled, no irq
        {4'b0001, 8'h99, 8'h3C, 1'b1},  // R5 irq without load
        {4'b0011, 8'h77, 8'h00, 1'b1},  // R4 R8 inject, flag kept
        {4'b0100, 8'h55, 8'h00, 1'b0},  // R7 clear
        {4'b0011, 8'h81, 8'h81, 1'b0},  // R2 disabled load
        {4'b1100, 8'h00, 8'h81, 1'b0},  // R7 set+clr, clear wins
        {4'b1000, 8'h00, 8'h81, 1'b1},  // R6 set
        {4'b0011, 8'hFF, 8'h00, 1'b1},  // R8 level still held, injects
        {4'b0010, 8'h42, 8'h42, 1'b1},  // R3 irq dropped
        {4'b0111, 8'hEE, 8'h00, 1'b0},  // R4 clr same cycle uses old flag
        {4'b0011, 8'h5A, 8'h5A, 1'b0}   // R2 now disabled
    };

    task automatic check(input string req, input logic [7:0] eo, input logic ei);
        n_run++;
        if (opcode !== eo || ien !== ei) begin
            n_fail++;
            $display("FAIL %s: opcode=%02h ien=%0b expected opcode=%02h ien=%0b",
                     req, opcode, ien, eo, ei);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            {ien_set, ien_clr, op_load, irq_req} = TBL[i][20:17];
            bus_din = TBL[i][16:9];
            @(negedge clk);
            check($sformatf("vector %0d R2-R8 table", i), TBL[i][8:1], TBL[i][0]);
        end
        {ien_set, ien_clr, op_load, irq_req} = 4'b0000;

        // R6 enable, then R4: no change before the edge, zero after
        ien_set = 1'b1;
        @(negedge clk);
        ien_set = 1'b0;
        check("R6 set again", 8'h5A, 1'b1);
        op_load = 1'b1; irq_req = 1'b1; bus_din = 8'hC3;
        #1;
        check("R4 opcode unchanged before edge", 8'h5A, 1'b1);
        @(negedge clk);
        op_load = 1'b0;
        check("R4 injected at edge", 8'h00, 1'b1);

        // R5 long hold with irq toggling and bus changing
        for (int k = 0; k < 6; k++) begin
            irq_req = k[0];
            bus_din = 8'(k * 37 + 1);
            @(negedge clk);
        end
        check("R5 hold under toggling irq", 8'h00, 1'b1);

        // R1 mid-run reset
        op_load = 1'b1; irq_req = 1'b0; bus_din = 8'h6D;
        @(negedge clk);
        op_load = 1'b0;
        check("R3 load before reset", 8'h6D, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after mid-run reset", 8'h00, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule